// File: doc/BRIEF.md
# Interrupt enable number controller

This block keeps one enable flag for each of a parameterised set of interrupt sources, numbered from 1 up to `NSRC` (63 by default). Software never writes the enable vector as a whole. It changes the vector through three kinds of write-only register. The set-by-number register turns on the one source whose number is written. The clear-by-number register turns that source off. A bank of clear-mask words turns off every source whose bit is set in the word written.

Each source also has a 3-bit mode supplied from outside the block. A mode of zero marks the source inactive, and an inactive source ignores every enable write. The full enable vector goes straight to the downstream gateway and claim logic. Reads of any of these registers return zero.

An access to an address the block does not decode raises a not-found flag for one cycle and has no other effect. This includes an address that is not word aligned.

Top module: `ien_ctrl`

## Requirements
- R1: A write of value n, with 1 <= n <= NSRC, to offset 0x1EDC sets the enable of source n (`enable_o[n-1]`) on the clock edge that samples the write, so the new value is visible in the next cycle.
- R2: A write of value n, with 1 <= n <= NSRC, to offset 0x1FDC clears the enable of source n with the same one-cycle latency.
- R3: A number write whose full 32-bit value is 0 or greater than NSRC changes no enable bit.
- R4: A source whose mode field (`mode_i[3*(n-1) +: 3]`) is 0 keeps its enable bit through any write. Every nonzero mode value (1 to 7) counts as active.
- R5: A write of data d to offset 0x1F00 + 4*k clears, for each set bit i of d, the enable of source 32*k + i. Bit 0 of word 0 and bits naming numbers above NSRC are ignored. Word k is decoded for k < ceil((NSRC+1)/32).
- R6: A read of any decoded register returns `rdata_o` = 0 and changes no enable bit, whatever the value on `wdata_i`.
- R7: An access whose address is not word aligned, or is not one of the decoded registers, makes `not_found_o` high in the next cycle and changes no enable bit. A decoded access leaves `not_found_o` low.
- R8: While reset is asserted, all enable bits and `not_found_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | AW | Byte offset of the access |
| wdata_i | input | 32 | Write data (source number or mask word) |
| mode_i | input | 3*NSRC | Mode of each source; source n occupies bits [3*(n-1) +: 3] |
| rdata_o | output | 32 | Read data, always zero |
| not_found_o | output | 1 | Undecoded or misaligned access seen in the previous cycle |
| enable_o | output | NSRC | Enable vector; bit n-1 belongs to source n |

## Verification
The per-source assertions assume that `mode_i` is settled and free of X at each rising edge, because the same sampled mode both gates the update and serves as the assertion's antecedent. The not-found and idle-hold checks assume that `req_i` lasts one cycle per access, and that `we_i`, `addr_i` and `wdata_i` are valid only while it is high. The bench changes modes and drives every bus field at the falling edge, only between accesses. It holds each access for exactly one rising edge, then drops the strobe and samples the outputs at the next falling edge.

// File: rtl/ien_pkg.sv
package ien_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_OFF = '0;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SET_NUM,
    OP_CLR_NUM,
    OP_CLR_MASK
  } ien_op_e;
endpackage

// File: rtl/ien_decode.sv
module ien_decode
  import ien_pkg::*;
#(
  parameter int unsigned        AW            = 16,
  parameter int unsigned        NWORDS        = 2,
  parameter logic [AW-1:0]      SET_NUM_OFF   = 16'h1EDC,
  parameter logic [AW-1:0]      CLR_NUM_OFF   = 16'h1FDC,
  parameter logic [AW-1:0]      CLR_MASK_BASE = 16'h1F00,
  localparam int unsigned       WIDX_W        = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  output ien_op_e           op_o,
  output logic [WIDX_W-1:0] word_o,
  output logic              hit_o
);
  localparam logic [AW-1:0] MASK_END = CLR_MASK_BASE + AW'(4 * NWORDS);

  logic aligned, in_mask, is_set, is_clr;

  always_comb begin
    aligned = (addr_i[1:0] == 2'b00);
    in_mask = (addr_i >= CLR_MASK_BASE) && (addr_i < MASK_END);
    is_set  = (addr_i == SET_NUM_OFF);
    is_clr  = (addr_i == CLR_NUM_OFF);
    hit_o   = aligned && (is_set || is_clr || in_mask);
    word_o  = WIDX_W'((addr_i - CLR_MASK_BASE) >> 2);
    op_o    = OP_NONE;
    if (req_i && we_i && aligned) begin
      if (is_set)       op_o = OP_SET_NUM;
      else if (is_clr)  op_o = OP_CLR_NUM;
      else if (in_mask) op_o = OP_CLR_MASK;
    end
  end
endmodule

// File: rtl/ien_num_dec.sv
module ien_num_dec
  import ien_pkg::*;
#(
  parameter int unsigned NSRC = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] num_i,
  output logic [NSRC-1:0]   vec_o
);
  // full-width compare: numbers with upper bits set never match
  for (genvar j = 0; j < NSRC; j++) begin : g_src
    assign vec_o[j] = en_i && (num_i == DATA_W'(j + 1));
  end

  AST_NUM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vec_o)); // R3

  AST_NUM_ZERO_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_i == '0) |-> (vec_o == '0)); // R3
endmodule

// File: rtl/ien_mask_dec.sv
module ien_mask_dec
  import ien_pkg::*;
#(
  parameter int unsigned NSRC   = 63,
  parameter int unsigned NWORDS = 2,
  localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              en_i,
  input  logic [WIDX_W-1:0] word_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NSRC-1:0]   vec_o
);
  // source s lives at word s/32, bit s%32; source 0 has no slot
  for (genvar j = 0; j < NSRC; j++) begin : g_src
    localparam int unsigned SRC = j + 1;
    assign vec_o[j] = en_i && (word_i == WIDX_W'(SRC / 32)) && data_i[SRC % 32];
  end
endmodule

// File: rtl/ien_bank.sv
module ien_bank
  import ien_pkg::*;
#(
  parameter int unsigned NSRC = 63
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC*MODE_W-1:0] mode_i,
  input  logic [NSRC-1:0]        set_i,
  input  logic [NSRC-1:0]        clr_i,
  output logic [NSRC-1:0]        en_o
);
  logic [NSRC-1:0] en_q;

  for (genvar j = 0; j < NSRC; j++) begin : g_src
    logic active;
    assign active = (mode_i[j*MODE_W +: MODE_W] != MODE_OFF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     en_q[j] <= 1'b0;
      else if (active) en_q[j] <= (en_q[j] | set_i[j]) & ~clr_i[j];
    end

    AST_INACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[j*MODE_W +: MODE_W] == MODE_OFF) |=> $stable(en_q[j])); // R4

    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[j] && !clr_i[j] && mode_i[j*MODE_W +: MODE_W] != MODE_OFF) |=> en_q[j]); // R1

    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[j] && mode_i[j*MODE_W +: MODE_W] != MODE_OFF) |=> !en_q[j]); // R2
  end

  assign en_o = en_q;
endmodule

// File: rtl/ien_ctrl.sv
module ien_ctrl
  import ien_pkg::*;
#(
  parameter int unsigned   NSRC          = 63,
  parameter int unsigned   AW            = 16,
  parameter logic [AW-1:0] SET_NUM_OFF   = 16'h1EDC,
  parameter logic [AW-1:0] CLR_NUM_OFF   = 16'h1FDC,
  parameter logic [AW-1:0] CLR_MASK_BASE = 16'h1F00
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [NSRC*MODE_W-1:0] mode_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   not_found_o,
  output logic [NSRC-1:0]        enable_o
);
  localparam int unsigned NWORDS = (NSRC + 1 + DATA_W - 1) / DATA_W;
  localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  ien_op_e           op;
  logic [WIDX_W-1:0] word;
  logic              hit;
  logic [NSRC-1:0]   num_vec, mask_vec, set_vec, clr_vec;
  logic              nf_q;

  ien_decode #(
    .AW(AW), .NWORDS(NWORDS), .SET_NUM_OFF(SET_NUM_OFF),
    .CLR_NUM_OFF(CLR_NUM_OFF), .CLR_MASK_BASE(CLR_MASK_BASE)
  ) u_decode (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .op_o(op), .word_o(word), .hit_o(hit)
  );

  ien_num_dec #(.NSRC(NSRC)) u_num_dec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(op == OP_SET_NUM || op == OP_CLR_NUM),
    .num_i(wdata_i), .vec_o(num_vec)
  );

  ien_mask_dec #(.NSRC(NSRC), .NWORDS(NWORDS)) u_mask_dec (
    .en_i(op == OP_CLR_MASK), .word_i(word), .data_i(wdata_i), .vec_o(mask_vec)
  );

  assign set_vec = (op == OP_SET_NUM) ? num_vec : '0;
  assign clr_vec = ((op == OP_CLR_NUM) ? num_vec : '0) | mask_vec;

  ien_bank #(.NSRC(NSRC)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .set_i(set_vec), .clr_i(clr_vec), .en_o(enable_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nf_q <= 1'b0;
    else         nf_q <= req_i && !hit;
  end

  assign not_found_o = nf_q;
  assign rdata_o     = '0;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(enable_o)); // R6

  AST_NF_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |=> (not_found_o && $stable(enable_o))); // R7

  AST_HIT_NO_NF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit) |=> !not_found_o); // R7
endmodule

// File: tb/ien_ctrl_test.sv
module ien_ctrl_test;
  import ien_pkg::*;

  localparam int NSRC = 63;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [15:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [NSRC*3-1:0] mode_flat;
  logic [31:0]       rdata;
  logic              nf;
  logic [NSRC-1:0]   en;

  logic [2:0]      mode_b [1:NSRC];
  logic [NSRC-1:0] exp_en = '0;
  logic            last_nf;
  logic [31:0]     last_rd;
  int              n_chk = 0;
  int              n_fail = 0;
  bit              done = 0;

  always #5 clk = ~clk;

  always_comb
    for (int s = 1; s <= NSRC; s++) mode_flat[(s-1)*3 +: 3] = mode_b[s];

  ien_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mode_i(mode_flat), .rdata_o(rdata),
    .not_found_o(nf), .enable_o(en)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, expv);
    end
  endtask

  task automatic chk_en(input string req_tag);
    chk(en == exp_en, req_tag, 64'(en), 64'(exp_en));
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    last_rd = rdata;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
    last_nf = nf;
  endtask

  task automatic set_num(input logic [31:0] n);  access(1'b1, 16'h1EDC, n); endtask
  task automatic clr_num(input logic [31:0] n);  access(1'b1, 16'h1FDC, n); endtask

  task automatic t_reset();
    chk(en == '0, "R8", 64'(en), 64'h0);
    chk(nf == 1'b0, "R8", 64'(nf), 64'h0);
    chk(rdata == '0, "R6", 64'(rdata), 64'h0);
  endtask

  task automatic t_set_num();
    set_num(1);  exp_en[0]  = 1'b1; chk_en("R1");
    chk(last_nf == 1'b0, "R7", 64'(last_nf), 64'h0);
    set_num(63); exp_en[62] = 1'b1; chk_en("R1");
    set_num(32); exp_en[31] = 1'b1; chk_en("R1");
    set_num(2);  exp_en[1]  = 1'b1; chk_en("R4 detached mode counts active");
    set_num(10); exp_en[9]  = 1'b1; chk_en("R4 mode 7 counts active");
  endtask

  task automatic t_clr_num();
    clr_num(32); exp_en[31] = 1'b0; chk_en("R2");
    clr_num(32); chk_en("R2 clear of cleared source");
  endtask

  task automatic t_range();
    set_num(0);            chk_en("R3 set zero");
    set_num(64);           chk_en("R3 set 64");
    set_num(32'h0000_0101); chk_en("R3 set 257");
    set_num(32'h8000_0001); chk_en("R3 upper bits set");
    clr_num(0);            chk_en("R3 clear zero");
    clr_num(32'h1_0000 + 1); chk_en("R3 clear 65537");
  endtask

  task automatic t_inactive();
    set_num(5);  chk_en("R4 set inactive 5");
    set_num(40); chk_en("R4 set inactive 40");
    set_num(6);  exp_en[5] = 1'b1; chk_en("R1");
    @(negedge clk); mode_b[6] = 3'd0;
    clr_num(6);  chk_en("R4 clear while inactive");
    access(1'b1, 16'h1F00, 32'h0000_0040); chk_en("R4 mask clear while inactive");
    @(negedge clk); mode_b[6] = 3'd5;
    clr_num(6);  exp_en[5] = 1'b0; chk_en("R2 after reactivation");
  endtask

  task automatic t_mask();
    set_num(31); set_num(33); set_num(45); set_num(62);
    exp_en[30] = 1'b1; exp_en[32] = 1'b1; exp_en[44] = 1'b1; exp_en[61] = 1'b1;
    chk_en("R1");
    access(1'b1, 16'h1F00, 32'h0000_0001); chk_en("R5 bit0 word0 ignored");
    access(1'b1, 16'h1F00, 32'h8000_0003);
    exp_en[0] = 1'b0; exp_en[30] = 1'b0; chk_en("R5 word0");
    chk(last_nf == 1'b0, "R7", 64'(last_nf), 64'h0);
    access(1'b1, 16'h1F04, 32'h8000_0102);
    exp_en[32] = 1'b0; exp_en[62] = 1'b0; chk_en("R5 word1");
    chk(en[44] == 1'b1 && en[61] == 1'b1, "R5 untouched bits", 64'(en), 64'(exp_en));
  endtask

  task automatic t_read();
    set_num(20); exp_en[19] = 1'b1;
    access(1'b0, 16'h1EDC, 32'd7);
    chk(last_rd == '0, "R6 set-num read", 64'(last_rd), 64'h0); chk_en("R6");
    access(1'b0, 16'h1FDC, 32'd20);
    chk(last_rd == '0, "R6 clr-num read", 64'(last_rd), 64'h0); chk_en("R6");
    access(1'b0, 16'h1F04, 32'hFFFF_FFFF);
    chk(last_rd == '0, "R6 mask read", 64'(last_rd), 64'h0); chk_en("R6");
    chk(last_nf == 1'b0, "R7 decoded read", 64'(last_nf), 64'h0);
  endtask

  task automatic t_not_found();
    access(1'b1, 16'h1EDD, 32'd7);
    chk(last_nf == 1'b1, "R7 misaligned", 64'(last_nf), 64'h1); chk_en("R7");
    access(1'b1, 16'h1F02, 32'hFFFF_FFFF);
    chk(last_nf == 1'b1, "R7 misaligned mask", 64'(last_nf), 64'h1); chk_en("R7");
    access(1'b1, 16'h1000, 32'd7);
    chk(last_nf == 1'b1, "R7 unmapped", 64'(last_nf), 64'h1); chk_en("R7");
    access(1'b0, 16'h1F08, 32'd0);
    chk(last_nf == 1'b1, "R7 past last word", 64'(last_nf), 64'h1); chk_en("R7");
    access(1'b1, 16'h1F08, 32'hFFFF_FFFF);
    chk(last_nf == 1'b1, "R7 write past last word", 64'(last_nf), 64'h1); chk_en("R7");
    @(negedge clk);
    chk(nf == 1'b0, "R7 flag lasts one cycle", 64'(nf), 64'h0);
  endtask

  initial begin
    for (int s = 1; s <= NSRC; s++) mode_b[s] = 3'd4;
    mode_b[2] = 3'd1; mode_b[5] = 3'd0; mode_b[10] = 3'd7;
    mode_b[40] = 3'd0; mode_b[63] = 3'd6;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_set_num();
    t_clr_num();
    t_range();
    t_inactive();
    t_mask();
    t_read();
    t_not_found();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule